// File: doc/BRIEF.md
# Word FIFO with Watermark-Driven DMA Request

This block is a synchronous first-in first-out buffer of 32-bit words that sits behind a peripheral bus data port. A processor or DMA engine pushes words with a write strobe and pops them with a read strobe. Every access must carry all four byte enables. Partial accesses, reads of an empty FIFO and writes to a full FIFO are refused. Each refusal sets a sticky flag that software clears by writing ones to a clear mask.

A hysteresis alarm watches the fill level against two programmable watermarks. One watermark sets the alarm and the other clears it. The direction input decides whether the alarm asks for a refill (transmit) or for draining (receive), and the alarm drives the matching DMA request line. A FIFO clear input empties the buffer in a single cycle and keeps the watermark settings.

Top module: `wm_dma_fifo`

## Requirements
- R1: While reset is active and after it is released, empty reads 1 and err, uf, of, full, alarm, dma_fill_req and dma_drain_req read 0.
- R2: Accepted words come out in the order they were written. rdata shows the head word combinationally during an accepted read and is 0 in every other cycle. full is 1 exactly when DEPTH words are held and empty is 1 exactly when none are held.
- R3: A write with all byte enables while full is refused. It leaves the stored data and the level unchanged and sets of on the next edge. A read in the same cycle still pops.
- R4: A read with all byte enables while empty is refused. rdata is 0, the level is unchanged and uf sets on the next edge. A write in the same cycle still pushes.
- R5: An access with byte enables other than 4'b1111 moves no pointer, stores nothing and returns rdata 0. It sets err on the next edge without setting uf or of.
- R6: err is set whenever uf or of is set. Clear-mask bit 2 clears err only if uf and of are both 0 after that same edge's update.
- R7: Clear-mask bit 1 clears uf and bit 0 clears of. A refusal event in the same cycle as its clear bit leaves the flag set.
- R8: With dir_rx=0, on each edge the alarm sets if the level before the edge is at or below wm_alarm. Otherwise it clears if that level is at or above wm_gran, and otherwise it holds.
- R9: With dir_rx=1, on each edge the alarm sets if the level before the edge is above wm_alarm. Otherwise it clears if that level is below wm_gran, and otherwise it holds.
- R10: dma_fill_req equals the alarm while dir_rx=0 and dma_drain_req equals the alarm while dir_rx=1. The other line is 0.
- R11: fifo_clr empties the FIFO and clears uf and of on the next edge. Accesses in that cycle are dropped and raise no flag. err and the watermark inputs are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_clr | input | 1 | Synchronous FIFO clear |
| dir_rx | input | 1 | 0 = transmit (refill) alarm sense, 1 = receive (drain) alarm sense |
| wm_alarm | input | LVL_W | Alarm set watermark, 0 to DEPTH |
| wm_gran | input | LVL_W | Alarm clear watermark, 0 to DEPTH |
| wr_en | input | 1 | Data port write strobe |
| rd_en | input | 1 | Data port read strobe |
| be | input | 4 | Byte enables of the data port access |
| wdata | input | 32 | Write data word |
| rdata | output | 32 | Read data word |
| clr_mask | input | 3 | Write-one-to-clear mask: bit 2 err, bit 1 uf, bit 0 of |
| err | output | 1 | Sticky summary error |
| uf | output | 1 | Sticky underflow |
| of | output | 1 | Sticky overflow |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no words |
| alarm | output | 1 | Watermark alarm |
| dma_fill_req | output | 1 | DMA refill request (transmit) |
| dma_drain_req | output | 1 | DMA drain request (receive) |

## Verification
The same cycle can carry a refusal event and a write-one-to-clear of the same flag. The bench provokes this by reading an empty FIFO while clear-mask bit 1 is high. It judges the result by requiring uf to stay set and err to survive a clear that arrives while uf or of is still set. A second collision pairs a push with a pop on an empty or a full FIFO, where one half is refused and the other proceeds. A sweep over every watermark pair in both directions compares the alarm edge by edge against an arithmetic model of the level.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = 4;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } wmf_dir_e;

  typedef struct packed {
    logic err;
    logic uf;
    logic of;
  } wmf_flags_t;
endpackage

// File: rtl/wmf_rst_sync.sv
module wmf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wmf_ctrl.sv
module wmf_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_clr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       be,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [LVL_W-1:0] level,
  output logic             push,
  output logic             pop,
  output logic             uf_evt,
  output logic             of_evt,
  output logic             acc_evt,
  output logic             full,
  output logic             empty
);
  localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(DEPTH);

  logic             legal;
  logic [AW-1:0]    wptr_n, rptr_n;
  logic [LVL_W-1:0] level_n;
  logic             ptr_en;

  assign legal = &be;
  assign full  = (level == LVL_MAX);
  assign empty = (level == '0);

  always_comb begin
    push    = wr_en & legal & ~full  & ~fifo_clr;
    pop     = rd_en & legal & ~empty & ~fifo_clr;
    of_evt  = wr_en & legal &  full  & ~fifo_clr;
    uf_evt  = rd_en & legal &  empty & ~fifo_clr;
    acc_evt = (wr_en | rd_en) & ~legal & ~fifo_clr;
  end

  always_comb begin
    wptr_n  = wptr;
    rptr_n  = rptr;
    level_n = level;
    if (fifo_clr) begin
      wptr_n  = '0;
      rptr_n  = '0;
      level_n = '0;
    end else begin
      if (push) wptr_n = (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr_n = (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   level_n = level + 1'b1;
        2'b01:   level_n = level - 1'b1;
        default: level_n = level;
      endcase
    end
  end

  assign ptr_en = fifo_clr | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (ptr_en) begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      level <= level_n;
    end
  end
endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wmf_alarm.sv
module wmf_alarm #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wmf_pkg::wmf_dir_e dir,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] wm_set,
  input  logic [LVL_W-1:0] wm_clr,
  output logic             alarm
);
  logic set_hit, clr_hit, alarm_n;

  always_comb begin
    if (dir == wmf_pkg::DIR_TX) begin
      set_hit = (level <= wm_set);
      clr_hit = (level >= wm_clr);
    end else begin
      set_hit = (level > wm_set);
      clr_hit = (level < wm_clr);
    end
    if (set_hit)      alarm_n = 1'b1;
    else if (clr_hit) alarm_n = 1'b0;
    else              alarm_n = alarm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm <= 1'b0;
    else        alarm <= alarm_n;
  end
endmodule

// File: rtl/wmf_status.sv
module wmf_status (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fifo_clr,
  input  logic                uf_evt,
  input  logic                of_evt,
  input  logic                acc_evt,
  input  wmf_pkg::wmf_flags_t clr,
  output wmf_pkg::wmf_flags_t flags
);
  wmf_pkg::wmf_flags_t flags_n;
  logic                flag_en;

  always_comb begin
    flags_n.uf = fifo_clr ? 1'b0 : (uf_evt | (flags.uf & ~clr.uf));
    flags_n.of = fifo_clr ? 1'b0 : (of_evt | (flags.of & ~clr.of));
    if (uf_evt | of_evt | acc_evt)
      flags_n.err = 1'b1;
    else if (clr.err & ~flags_n.uf & ~flags_n.of)
      flags_n.err = 1'b0;
    else
      flags_n.err = flags.err;
  end

  assign flag_en = fifo_clr | uf_evt | of_evt | acc_evt | (|clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_en) flags <= flags_n;
  end
endmodule

// File: rtl/wm_dma_fifo.sv
module wm_dma_fifo #(
  parameter int DEPTH  = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_clr,
  input  logic             dir_rx,
  input  logic [LVL_W-1:0] wm_alarm,
  input  logic [LVL_W-1:0] wm_gran,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [2:0]       clr_mask,
  output logic             err,
  output logic             uf,
  output logic             of,
  output logic             full,
  output logic             empty,
  output logic             alarm,
  output logic             dma_fill_req,
  output logic             dma_drain_req
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                rst_sync_n;
  logic [AW-1:0]       wptr, rptr;
  logic [LVL_W-1:0]    level;
  logic                push, pop, uf_evt, of_evt, acc_evt;
  logic [31:0]         head_word;
  wmf_pkg::wmf_flags_t flags, clr_flags;
  wmf_pkg::wmf_dir_e   dir;

  assign dir       = dir_rx ? wmf_pkg::DIR_RX : wmf_pkg::DIR_TX;
  assign clr_flags = wmf_pkg::wmf_flags_t'(clr_mask);

  wmf_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  wmf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fifo_clr (fifo_clr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .be       (be),
    .wptr     (wptr),
    .rptr     (rptr),
    .level    (level),
    .push     (push),
    .pop      (pop),
    .uf_evt   (uf_evt),
    .of_evt   (of_evt),
    .acc_evt  (acc_evt),
    .full     (full),
    .empty    (empty)
  );

  wmf_store #(.DEPTH(DEPTH), .W(wmf_pkg::WORD_W)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (wdata),
    .raddr (rptr),
    .rdata (head_word)
  );

  wmf_alarm #(.LVL_W(LVL_W)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .dir    (dir),
    .level  (level),
    .wm_set (wm_alarm),
    .wm_clr (wm_gran),
    .alarm  (alarm)
  );

  wmf_status u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fifo_clr (fifo_clr),
    .uf_evt   (uf_evt),
    .of_evt   (of_evt),
    .acc_evt  (acc_evt),
    .clr      (clr_flags),
    .flags    (flags)
  );

  assign rdata         = pop ? head_word : '0;
  assign err           = flags.err;
  assign uf            = flags.uf;
  assign of            = flags.of;
  assign dma_fill_req  = alarm & (dir == wmf_pkg::DIR_TX);
  assign dma_drain_req = alarm & (dir == wmf_pkg::DIR_RX);
endmodule

// File: rtl/wmf_chk.sv
module wmf_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        fifo_clr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  be,
  input logic [31:0] rdata,
  input logic        err,
  input logic        uf,
  input logic        of,
  input logic        full,
  input logic        empty,
  input logic        dma_fill_req,
  input logic        dma_drain_req
);
  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(full && empty));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (be == 4'hF) && full && !rd_en && !fifo_clr) |=> (full && of));

  assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && empty) |-> (rdata == 32'd0));

  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && (be == 4'hF) && empty && !fifo_clr) |=> uf);

  assert_partial_err_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((wr_en || rd_en) && (be != 4'hF) && !fifo_clr) |=> (err && $stable(full) && $stable(empty)));

  assert_err_covers_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (uf || of) |-> err);

  assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dma_fill_req && dma_drain_req));

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_clr |=> (empty && !uf && !of));
endmodule

bind wm_dma_fifo wmf_chk u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .fifo_clr      (fifo_clr),
  .wr_en         (wr_en),
  .rd_en         (rd_en),
  .be            (be),
  .rdata         (rdata),
  .err           (err),
  .uf            (uf),
  .of            (of),
  .full          (full),
  .empty         (empty),
  .dma_fill_req  (dma_fill_req),
  .dma_drain_req (dma_drain_req)
);

// File: tb/tb_wm_dma_fifo.sv
`timescale 1ns/1ps
module tb_wm_dma_fifo;
  localparam int D  = 8;
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fifo_clr, dir_rx, wr_en, rd_en;
  logic [LW-1:0] wm_alarm, wm_gran;
  logic [3:0]    be;
  logic [31:0]   wdata, rdata;
  logic [2:0]    clr_mask;
  logic          err, uf, of, full, empty, alarm, dma_fill_req, dma_drain_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model
  int          m_lvl, m_head;
  logic [31:0] m_q [D];
  bit          m_alarm, m_uf, m_of, m_err;
  bit          nx_dir;
  int          nx_awm, nx_gwm;

  always #10 clk = ~clk;

  wm_dma_fifo #(.DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .dir_rx(dir_rx),
    .wm_alarm(wm_alarm), .wm_gran(wm_gran), .wr_en(wr_en), .rd_en(rd_en),
    .be(be), .wdata(wdata), .rdata(rdata), .clr_mask(clr_mask),
    .err(err), .uf(uf), .of(of), .full(full), .empty(empty), .alarm(alarm),
    .dma_fill_req(dma_fill_req), .dma_drain_req(dma_drain_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 full",  32'(full),  32'(m_lvl == D));
    chk("R2 empty", 32'(empty), 32'(m_lvl == 0));
    chk(dir_rx ? "R9 alarm" : "R8 alarm", 32'(alarm), 32'(m_alarm));
    chk("R10 fill",  32'(dma_fill_req),  32'(m_alarm && !dir_rx));
    chk("R10 drain", 32'(dma_drain_req), 32'(m_alarm && dir_rx));
    chk("R4 uf",  32'(uf),  32'(m_uf));
    chk("R3 of",  32'(of),  32'(m_of));
    chk("R6 err", 32'(err), 32'(m_err));
  endtask

  task automatic cyc(input bit w, input bit r, input logic [3:0] b,
                     input logic [31:0] d, input logic [2:0] cm, input bit fc);
    bit legal, ue, oe, pe, pu, po, nuf, nof, set_h, clr_h;
    int tail;
    @(negedge clk);
    compare_all();
    dir_rx   = nx_dir;
    wm_alarm = LW'(nx_awm);
    wm_gran  = LW'(nx_gwm);
    wr_en = w; rd_en = r; be = b; wdata = d; clr_mask = cm; fifo_clr = fc;
    #1;
    legal = (b == 4'hF);
    pu = !fc && w && legal && (m_lvl < D);
    po = !fc && r && legal && (m_lvl > 0);
    ue = !fc && r && legal && (m_lvl == 0);
    oe = !fc && w && legal && (m_lvl == D);
    pe = !fc && (w || r) && !legal;
    if (r) chk("R2 rdata", rdata, po ? m_q[m_head] : 32'd0);
    // alarm from level before the edge
    if (!nx_dir) begin set_h = (m_lvl <= nx_awm); clr_h = (m_lvl >= nx_gwm); end
    else         begin set_h = (m_lvl >  nx_awm); clr_h = (m_lvl <  nx_gwm); end
    if (set_h) m_alarm = 1;
    else if (clr_h) m_alarm = 0;
    nuf = fc ? 0 : (ue || (m_uf && !cm[1]));
    nof = fc ? 0 : (oe || (m_of && !cm[0]));
    if (ue || oe || pe) m_err = 1;
    else if (cm[2] && !nuf && !nof) m_err = 0;
    m_uf = nuf; m_of = nof;
    if (fc) begin
      m_lvl = 0; m_head = 0;
    end else begin
      tail = (m_head + m_lvl) % D;
      if (pu) m_q[tail] = d;
      if (po) m_head = (m_head + 1) % D;
      m_lvl = m_lvl + (pu ? 1 : 0) - (po ? 1 : 0);
    end
  endtask

  task automatic idle();
    cyc(0, 0, 4'hF, 32'd0, 3'd0, 0);
  endtask

  initial begin
    rst_n = 0; fifo_clr = 0; dir_rx = 1; wr_en = 0; rd_en = 0;
    be = 4'hF; wdata = '0; clr_mask = '0; wm_alarm = '0; wm_gran = '0;
    nx_dir = 1; nx_awm = 0; nx_gwm = 0;
    m_lvl = 0; m_head = 0; m_alarm = 0; m_uf = 0; m_of = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values during reset
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 flags", {28'd0, err, uf, of, full}, 32'd0);
    chk("R1 alarm", {29'd0, alarm, dma_fill_req, dma_drain_req}, 32'd0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 empty after release", 32'(empty), 32'd1);
    chk("R1 flags after release", {28'd0, err, uf, of, full}, 32'd0);

    // sweep both directions and every watermark pair
    for (int dr = 0; dr < 2; dr++)
      for (int a = 0; a <= D; a++)
        for (int g = 0; g <= D; g++) begin
          nx_dir = dr[0]; nx_awm = a; nx_gwm = g;
          cyc(0, 0, 4'hF, 32'd0, 3'b111, 1);
          for (int k = 0; k <= D; k++) cyc(1, 0, 4'hF, {dr[7:0], a[7:0], g[7:0], k[7:0]}, 3'd0, 0);
          for (int k = 0; k <= D; k++) cyc(0, 1, 4'hF, 32'd0, 3'd0, 0);
        end

    // directed corner cases, transmit, set at 2, clear at 5
    nx_dir = 0; nx_awm = 2; nx_gwm = 5;
    cyc(0, 0, 4'hF, 32'd0, 3'b111, 1);
    idle();
    chk("R6 err cleared when uf/of clear", 32'(err), 32'd0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 4'hF, 32'hA000 + k, 3'd0, 0);
    cyc(1, 0, 4'b0111, 32'hDEAD, 3'd0, 0);       // R5 partial write
    cyc(0, 1, 4'b1100, 32'd0, 3'd0, 0);          // R5 partial read
    chk("R5 partial read data", rdata, 32'd0);
    idle();
    chk("R5 err after partial", 32'(err), 32'd1);
    chk("R5 no uf/of", {30'd0, uf, of}, 32'd0);
    for (int k = 0; k < 3; k++) cyc(0, 1, 4'hF, 32'd0, 3'd0, 0);  // R5 order intact
    cyc(0, 0, 4'hF, 32'd0, 3'b100, 0);
    cyc(1, 1, 4'hF, 32'hB0B0, 3'd0, 0);          // R4 push proceeds, pop refused
    chk("R4 rdata zero on empty read", rdata, 32'd0);
    idle();
    chk("R4 uf set", 32'(uf), 32'd1);
    chk("R4 word kept", 32'(empty), 32'd0);
    cyc(0, 1, 4'hF, 32'd0, 3'd0, 0);
    cyc(0, 1, 4'hF, 32'd0, 3'b010, 0);           // R7 event wins over clear
    idle();
    chk("R7 uf stays on collision", 32'(uf), 32'd1);
    cyc(0, 0, 4'hF, 32'd0, 3'b100, 0);           // R6 err clear refused while uf
    idle();
    chk("R6 err held while uf", 32'(err), 32'd1);
    cyc(0, 0, 4'hF, 32'd0, 3'b010, 0);
    idle();
    chk("R7 uf cleared", 32'(uf), 32'd0);
    chk("R6 err still set", 32'(err), 32'd1);
    cyc(0, 0, 4'hF, 32'd0, 3'b100, 0);
    idle();
    chk("R6 err cleared", 32'(err), 32'd0);
    for (int k = 0; k < D; k++) cyc(1, 0, 4'hF, 32'hC000 + k, 3'd0, 0);
    cyc(1, 1, 4'hF, 32'hEEEE, 3'd0, 0);          // R3 pop proceeds, push refused
    idle();
    chk("R3 of set", 32'(of), 32'd1);
    chk("R3 level dropped", 32'(full), 32'd0);
    cyc(0, 0, 4'hF, 32'd0, 3'b001, 0);
    idle();
    chk("R7 of cleared", 32'(of), 32'd0);
    for (int k = 0; k < D - 1; k++) cyc(0, 1, 4'hF, 32'd0, 3'd0, 0);
    cyc(1, 0, 4'hF, 32'h1, 3'd0, 0);
    cyc(1, 0, 4'b0001, 32'h2, 3'd0, 0);          // err set
    cyc(0, 1, 4'hF, 32'd0, 3'd0, 0);
    cyc(0, 1, 4'hF, 32'd0, 3'd0, 0);             // uf set
    cyc(1, 0, 4'hF, 32'h3, 3'd0, 1);             // R11 clear with write
    idle();
    chk("R11 empty", 32'(empty), 32'd1);
    chk("R11 uf/of cleared", {30'd0, uf, of}, 32'd0);
    chk("R11 err kept", 32'(err), 32'd1);
    idle();
    chk("R11 watermarks kept, alarm", 32'(alarm), 32'd1);
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule